// File: doc/BRIEF.md
# Trace Buffer Read Window

This block holds a small trace memory of 64-bit entries and lets a bus master read it through a single 16-bit register window. Each entry comes out as four successive 16-bit words, most significant word first. An internal read pointer selects the entry and the word within it. The pointer moves on only after a read that is fully valid. Capture logic elsewhere fills the memory through a valid/ready store port.

Reads are guarded by three conditions. While the `arm` input is high, the buffer is locked and every read returns zero. The lock stays in place after `arm` falls. Only an aligned full-word write to the window, made while disarmed, lifts the lock. That write carries no payload and leaves the stored trace untouched, so the bus has no write-data pin.

A byte read or a read at the odd byte address returns zero and leaves the pointer where it is. The store port takes entries only while armed: `st_ready` follows `arm`, and a producer must hold `st_valid` and `st_data` until it sees `st_ready` high on a clock edge. While disarmed the producer is stalled, and the write pointer is held at entry 0.

Top module: `trace_read_window`

## Requirements
- R1: After reset the buffer is locked and both pointers are at entry 0, slice 0. A read returns zero until an unlock write is made, and `rd_data` is zero whenever `bus_rd` is low.
- R2: `st_ready` equals `arm`. A store handshake (`st_valid` and `st_ready` high at a clock edge) writes `st_data` into the entry at the write pointer. The write pointer then advances by one and wraps from DEPTH-1 to 0. While `arm` is low, the write pointer is returned to 0.
- R3: A valid read returns, in the same cycle, slice s of the entry under the read pointer. A valid read has `bus_rd` high, `bus_addr` equal to WIN_ADDR (an even address), `bus_be` equal to 2'b11, `arm` low and the buffer unlocked. Slice 0 is bits 63:48 and slice 3 is bits 15:0.
- R4: On the clock edge after a valid read, the slice index advances. After slice 3 it goes to slice 0 of the next entry, and entry DEPTH-1 wraps to entry 0.
- R5: Any cycle with `arm` high locks the buffer. It stays locked after `arm` falls, until a valid unlock write.
- R6: An unlock write is `bus_wr` high, `bus_addr` equal to WIN_ADDR, `bus_be` equal to 2'b11 and `arm` low. It clears the lock, sets the read pointer to entry 0 slice 0, and does not alter the stored entries. A write with `arm` high, a partial byte enable, or an odd address leaves the buffer locked.
- R7: A byte read (`bus_be` 2'b01 or 2'b10) or a read at WIN_ADDR+1 returns zero and does not move the read pointer.
- R8: A read while `arm` is high, or while locked, returns zero and does not move the read pointer.
- R9: Reset does not change the stored trace entries.
- R10: When an unlock write and a valid read occur in the same cycle, the read returns the slice under the current pointer, and the pointer then goes to entry 0 slice 0.
- R11: A read at any address other than WIN_ADDR or WIN_ADDR+1 returns zero and does not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables, bit 0 for the even byte |
| rd_data | output | 16 | Read data, valid in the cycle of `bus_rd` |
| arm | input | 1 | Debug arm control; locks the buffer and opens capture |
| st_valid | input | 1 | Store entry offered |
| st_ready | output | 1 | Store entry accepted (equals `arm`) |
| st_data | input | 64 | Trace entry to store |

## Verification
The pair that can meet in one cycle is an unlock write and a valid read: the bus strobes both `bus_rd` and `bus_wr` at the window while the buffer is already open and disarmed. A directed case places this after two reads of entry 0. It expects the third slice of entry 0 on `rd_data` and slice 0 of entry 0 on the next read. The random phase mixes simultaneous read and write strobes with arming, partial byte enables and stray addresses. Every read is compared with a bench model that applies the unlock-over-advance priority.

// File: rtl/tbw_pkg.sv
`timescale 1ns/1ps
package tbw_pkg;

  // Decoded view of one bus cycle
  typedef struct packed {
    logic rd_ok;   // read that returns data and advances
    logic unlock;  // aligned word write while disarmed
  } tbw_dec_t;

  // Pick one word from a line, word 0 being the most significant
  function automatic logic [15:0] pick_word(input logic [63:0] line, input int unsigned sel);
    return line[(3 - sel) * 16 +: 16];
  endfunction

endpackage

// File: rtl/tbw_decode.sv
`timescale 1ns/1ps
module tbw_decode
  import tbw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BE_W     = 2,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 8'h24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic              arm,
  input  logic              locked,
  output tbw_dec_t          dec
);
  logic hit_word;

  always_comb begin
    hit_word   = (addr == WIN_ADDR) && (addr[0] == 1'b0) && (&be);
    dec.rd_ok  = rd && hit_word && !arm && !locked;
    dec.unlock = wr && hit_word && !arm;
  end
endmodule

// File: rtl/tbw_lock_ptr.sv
`timescale 1ns/1ps
module tbw_lock_ptr #(
  parameter int DEPTH  = 16,
  parameter int SLICES = 4,
  localparam int ENT_W = $clog2(DEPTH),
  localparam int SL_W  = $clog2(SLICES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rd_ok,
  input  logic             unlock,
  output logic             locked,
  output logic [ENT_W-1:0] ent_idx,
  output logic [SL_W-1:0]  sl_idx
);
  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(DEPTH - 1);
  localparam logic [SL_W-1:0]  LAST_SL  = SL_W'(SLICES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b1;
      ent_idx <= '0;
      sl_idx  <= '0;
    end else begin
      if (arm)         locked <= 1'b1;
      else if (unlock) locked <= 1'b0;

      if (unlock) begin
        ent_idx <= '0;
        sl_idx  <= '0;
      end else if (rd_ok) begin
        if (sl_idx == LAST_SL) begin
          sl_idx  <= '0;
          ent_idx <= (ent_idx == LAST_ENT) ? '0 : ent_idx + 1'b1;
        end else begin
          sl_idx <= sl_idx + 1'b1;
        end
      end
    end
  end

  // R5: arming leaves the buffer locked
  a_r5_arm_locks: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> locked);
  // R6: unlock rewinds the read pointer
  a_r6_unlock_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (ent_idx == '0 && sl_idx == '0));
  // R7: no valid read, no unlock -> pointer holds
  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ok && !unlock) |=> ($stable(ent_idx) && $stable(sl_idx)));
  // R4: last slice rolls over to slice 0
  a_r4_slice_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !unlock && sl_idx == LAST_SL) |=> (sl_idx == '0));
  // R8: armed reads never count as valid
  a_r8_no_read_armed: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !rd_ok);
endmodule

// File: rtl/tbw_store.sv
`timescale 1ns/1ps
module tbw_store #(
  parameter int DEPTH  = 16,
  parameter int LINE_W = 64,
  localparam int ENT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [LINE_W-1:0] st_data,
  input  logic [ENT_W-1:0]  rd_ent,
  output logic [LINE_W-1:0] rd_line
);
  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(DEPTH - 1);

  logic [LINE_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0]  wptr;
  logic              take;

  assign st_ready = arm;
  assign take     = st_valid && st_ready;
  assign rd_line  = mem[rd_ent];

  // Trace contents carry no reset
  always_ff @(posedge clk) begin
    if (take) mem[wptr] <= st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wptr <= '0;
    else if (!arm)  wptr <= '0;
    else if (take)  wptr <= (wptr == LAST_ENT) ? '0 : wptr + 1'b1;
  end

  // R2: disarmed cycles rewind the capture pointer
  a_r2_wptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (wptr == '0));
  // R2: an accepted store steps the capture pointer
  a_r2_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wptr != LAST_ENT) |=> (wptr == $past(wptr) + 1'b1));
endmodule

// File: rtl/trace_read_window.sv
`timescale 1ns/1ps
module trace_read_window
  import tbw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 8'h24,
  localparam int LINE_W = 64,
  localparam int WORD_W = 16,
  localparam int BE_W   = WORD_W / 8,
  localparam int SLICES = LINE_W / WORD_W,
  localparam int ENT_W  = $clog2(DEPTH),
  localparam int SL_W   = $clog2(SLICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BE_W-1:0]   bus_be,
  output logic [WORD_W-1:0] rd_data,
  input  logic              arm,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [LINE_W-1:0] st_data
);
  tbw_dec_t          dec;
  logic              locked;
  logic [ENT_W-1:0]  ent_idx;
  logic [SL_W-1:0]   sl_idx;
  logic [LINE_W-1:0] cur_line;

  tbw_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W), .WIN_ADDR(WIN_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .be(bus_be),
    .arm(arm), .locked(locked), .dec(dec)
  );

  tbw_lock_ptr #(.DEPTH(DEPTH), .SLICES(SLICES)) u_lock (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rd_ok(dec.rd_ok),
    .unlock(dec.unlock), .locked(locked), .ent_idx(ent_idx), .sl_idx(sl_idx)
  );

  tbw_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .arm(arm), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .rd_ent(ent_idx), .rd_line(cur_line)
  );

  always_comb begin
    rd_data = '0;
    if (dec.rd_ok) rd_data = pick_word(cur_line, int'(sl_idx));
  end

  // R8: armed reads return zero
  a_r8_armed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && arm) |-> (rd_data == '0));
  // R1: idle bus drives zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rd_data == '0));
  // R7: partial byte enables return zero
  a_r7_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !(&bus_be)) |-> (rd_data == '0));
endmodule

// File: tb/sim_trace_read_window.sv
`timescale 1ns/1ps
module sim_trace_read_window;
  localparam logic [7:0] WIN = 8'h24;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] rd_data;
  logic        arm = 1'b0, st_valid = 1'b0, st_ready;
  logic [63:0] st_data = '0;

  trace_read_window u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_be(bus_be), .rd_data(rd_data), .arm(arm),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [63:0] m_mem [DEPTH];
  bit m_locked = 1;
  int m_ent = 0, m_sl = 0, m_wp = 0;

  function automatic logic [15:0] exp_word(input logic [63:0] line, input int s);
    return 16'(line >> ((3 - s) * 16));
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_locked = 1; m_ent = 0; m_sl = 0; m_wp = 0;
  endtask

  // One bus cycle: drive after negedge, check before posedge, update model
  task automatic step(input bit a, input bit r, input bit w, input logic [1:0] b,
                      input logic [7:0] ad, input bit sv, input logic [63:0] sd,
                      input string req);
    bit ok, unl;
    logic [15:0] e;
    arm = a; bus_rd = r; bus_wr = w; bus_be = b; bus_addr = ad;
    st_valid = sv; st_data = sd;
    #4;
    ok  = r && ad == WIN && b == 2'b11 && !a && !m_locked;
    unl = w && ad == WIN && b == 2'b11 && !a;
    e   = ok ? exp_word(m_mem[m_ent], m_sl) : 16'h0;
    check(req, rd_data, e);
    check("R2", st_ready, a);
    if (a && sv) begin
      m_mem[m_wp] = sd;
      m_wp = (m_wp + 1) % DEPTH;
    end
    if (!a) m_wp = 0;
    if (a) m_locked = 1; else if (unl) m_locked = 0;
    if (unl) begin m_ent = 0; m_sl = 0; end
    else if (ok) begin
      if (m_sl == 3) begin m_sl = 0; m_ent = (m_ent + 1) % DEPTH; end
      else m_sl++;
    end
    @(negedge clk);
  endtask

  task automatic rd(input string req);
    step(0, 1, 0, 2'b11, WIN, 0, '0, req);
  endtask
  task automatic unlock_wr();
    step(0, 0, 1, 2'b11, WIN, 0, '0, "R6");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; arm = 0; bus_rd = 0; bus_wr = 0; st_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // R1: reset state
    check("R1", st_ready, 1'b0);
    rd("R1");
    step(0, 0, 0, 2'b11, WIN, 0, '0, "R1");
    // R2: fill plus two wrapping stores
    for (int i = 0; i < DEPTH + 2; i++)
      step(1, 0, 0, 2'b00, 8'h00, 1, {16'(i), 16'hA000 + 16'(i), 16'hB000 + 16'(i), 16'hC000 + 16'(i)}, "R2");
    step(1, 0, 0, 2'b00, 8'h00, 0, 64'hDEAD, "R2");
    step(0, 0, 0, 2'b00, 8'h00, 1, 64'hBAD, "R2");   // not accepted while disarmed
    // R5: still locked after arm falls
    rd("R5");
    step(0, 0, 1, 2'b01, WIN, 0, '0, "R6");
    step(0, 0, 1, 2'b11, WIN + 8'd1, 0, '0, "R6");
    rd("R6");
    unlock_wr();
    rd("R3"); rd("R3");
    step(0, 1, 0, 2'b01, WIN, 0, '0, "R7");
    step(0, 1, 0, 2'b10, WIN, 0, '0, "R7");
    step(0, 1, 0, 2'b11, WIN + 8'd1, 0, '0, "R7");
    step(0, 1, 0, 2'b11, 8'h40, 0, '0, "R11");
    rd("R7"); rd("R7");
    // R4: walk all entries and wrap
    for (int i = 0; i < DEPTH * 4 + 3; i++) rd("R4");
    // R8: armed reads
    step(1, 1, 0, 2'b11, WIN, 0, '0, "R8");
    step(1, 0, 1, 2'b11, WIN, 0, '0, "R6");
    step(0, 1, 0, 2'b11, WIN, 0, '0, "R8");
    // R10: unlock and read together
    unlock_wr();
    rd("R10"); rd("R10");
    step(0, 1, 1, 2'b11, WIN, 0, '0, "R10");
    rd("R10");
    // R9: contents survive reset
    do_reset();
    rd("R9");
    unlock_wr();
    for (int i = 0; i < 8; i++) rd("R9");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit a, r, w, sv;
      logic [1:0] b;
      logic [7:0] ad;
      int pick;
      a  = ($urandom_range(0, 19) == 0) ? !arm : arm;
      r  = $urandom_range(0, 1);
      w  = ($urandom_range(0, 9) == 0);
      b  = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11;
      pick = $urandom_range(0, 9);
      ad = (pick == 0) ? WIN + 8'd1 : (pick == 1) ? 8'($urandom) : WIN;
      sv = $urandom_range(0, 1);
      step(a, r, w, b, ad, sv, {$urandom, $urandom},
           (r && !a && !m_locked && ad == WIN && b == 2'b11) ? "R3" : (a ? "R8" : "R7"));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule